// File: doc/BRIEF.md
# Tagged Frame Ring Buffer with Drop Policy

This block sits between an image pipeline that emits pixel streams and an output engine that drains whole frames toward a host link. Incoming words are written into a ring of fixed-size slots. A slot becomes readable only when the end-of-frame word arrives. Each stored frame carries a sequence number and a timestamp that the block assigns. The output side reads frames in arrival order at its own pace. Each word it presents carries the frame's tags and a capture flag.

When the number of stored frames reaches a programmable near-full level, a selectable policy decides what happens to a new frame. The block can discard new preview frames, evict the oldest unread preview frame so the newest is kept, or raise a throttle toward the producer. Frames marked as capture are never silently lost. If no slot is free for one, the block throttles the producer and counts an overrun when the producer sends the frame anyway. Saturating counters report lost frames, the longest unbroken run of lost frames and overruns.

Top module: `frame_ring_buf`

## Requirements
- R1: Every start-of-frame beat advances the sequence number by one, whether the frame is kept or lost (the first frame after reset gets 0). The timestamp is a counter that advances every clock and is sampled on the start-of-frame beat. Both tags and the capture flag are presented with every word of the stored frame.
- R2: A frame becomes visible on the output only after its end-of-frame beat. While a frame is still being written, out_valid stays low if no earlier frame is stored.
- R3: Stored frames leave in arrival order with their data unchanged. out_sof marks the first word and out_eof the last. While out_ready is low in the middle of a frame, the presented word and tags hold.
- R4: Policy 0 (value 3 behaves the same) drops new frames. A preview frame whose start arrives while occupancy is at or above cfg_near_lvl is discarded and counted in drop_count.
- R5: Policy 1 keeps the latest frame. At a near-full start of a preview frame, the oldest stored frame is evicted and counted as a drop, and the new frame is stored. This happens only when the oldest frame is a preview frame and its readout has not begun.
- R6: Policy 2 throttles. in_throttle is high while occupancy is at or above cfg_near_lvl. A start-of-frame beat that arrives while the throttle is high discards that frame and counts it in overrun_count and in drop_count.
- R7: Under policies 0 and 1, a capture frame (in_capture high on its start beat) is stored whenever a slot is free. A stored capture frame is never evicted.
- R8: With every slot occupied, in_throttle is high under any policy. A capture frame started then is counted as an overrun and a drop. A preview frame started then is counted as a drop only.
- R9: A start-of-frame beat that arrives before the current frame's end discards the partial frame. The partial frame never becomes visible, counts as one drop, and its slot is reused.
- R10: drop_run_max holds the largest number of drops seen with no stored frame completing in between. Every counter saturates at its maximum.
- R11: After reset, out_valid is low, every counter reads zero and in_throttle is low, provided cfg_near_lvl is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_policy | input | 2 | Near-full policy: 0 drop new, 1 keep latest, 2 throttle |
| cfg_near_lvl | input | CW | Occupancy, in frames, at which the policy applies |
| in_valid | input | 1 | Input word valid |
| in_sof | input | 1 | First word of a frame |
| in_eof | input | 1 | Last word of a frame |
| in_capture | input | 1 | Frame is a capture frame (sampled with in_sof) |
| in_data | input | DATA_W | Input pixel word |
| in_throttle | output | 1 | Request to the producer to hold new frames |
| out_ready | input | 1 | Output side accepts the presented word |
| out_valid | output | 1 | A stored frame word is presented |
| out_sof | output | 1 | Presented word is the first of its frame |
| out_eof | output | 1 | Presented word is the last of its frame |
| out_data | output | DATA_W | Presented pixel word |
| out_seq | output | SEQ_W | Sequence tag of the presented frame |
| out_ts | output | TS_W | Timestamp tag of the presented frame |
| out_capture | output | 1 | Capture flag of the presented frame |
| drop_count | output | CNT_W | Frames lost (saturating) |
| drop_run_max | output | CNT_W | Longest run of consecutive losses |
| overrun_count | output | CNT_W | Frames started while throttled |

## Verification
A table of frame arrivals under the drop-new policy walks occupancy from empty to full. It mixes preview and capture frames, so a single pass separates policy drops, free-slot capture admission, forced throttling at full and capture overruns, and the drop counters diverge at each step. Separate sequences then exercise eviction. In one the oldest frame is a preview frame; in the other it is a capture frame, which shows whether eviction respects the capture flag. An abandoned partial frame followed by a full one shows whether storage happens only at frame end. Every drain compares sequence numbers with their gaps, and compares timestamp steps against the cycles the bench counted between frame starts. Together these show both tag values and that the frames leave in order.

// File: rtl/frb_pkg.sv
package frb_pkg;
  typedef enum logic [1:0] {
    POL_DROP_NEW    = 2'd0,
    POL_KEEP_LATEST = 2'd1,
    POL_THROTTLE    = 2'd2
  } policy_e;

  typedef enum logic [1:0] {
    ADM_STORE       = 2'd0,
    ADM_STORE_EVICT = 2'd1,
    ADM_DROP        = 2'd2,
    ADM_OVERRUN     = 2'd3
  } admit_e;
endpackage

// File: rtl/frb_admit.sv
// Start-of-frame admission decision and producer throttle.
module frb_admit
  import frb_pkg::*;
#(
  parameter int SLOTS = 4,
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic [1:0]    policy,
  input  logic [CW-1:0] near_lvl,
  input  logic [CW-1:0] occ,
  input  logic          capture,
  input  logic          can_evict,
  output logic          throttle,
  output admit_e        verdict
);
  logic full, near, pol_thr, pol_keep, pol_drop;

  always_comb begin
    full     = (occ == CW'(SLOTS));
    near     = (occ >= near_lvl);
    pol_thr  = (policy == POL_THROTTLE);
    pol_keep = (policy == POL_KEEP_LATEST);
    pol_drop = !pol_thr && !pol_keep;
    throttle = full || (pol_thr && near);
    if ((pol_thr && near) || (full && capture))
      verdict = ADM_OVERRUN;
    else if (full)
      verdict = ADM_DROP;
    else if (near && !capture && pol_drop)
      verdict = ADM_DROP;
    else if (near && !capture && pol_keep && can_evict)
      verdict = ADM_STORE_EVICT;
    else
      verdict = ADM_STORE;
  end
endmodule

// File: rtl/frb_store.sv
// Slot storage: pixel words plus per-slot header (tags, flag, length).
module frb_store #(
  parameter int DATA_W     = 8,
  parameter int SLOTS      = 4,
  parameter int SLOT_WORDS = 8,
  parameter int SEQ_W      = 8,
  parameter int TS_W       = 16,
  localparam int SW = $clog2(SLOTS),
  localparam int WW = $clog2(SLOT_WORDS),
  localparam int LW = $clog2(SLOT_WORDS + 1),
  localparam int AW = $clog2(SLOTS * SLOT_WORDS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SW-1:0]     wr_slot,
  input  logic [WW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LW-1:0]     wr_len,
  input  logic              hdr_we,
  input  logic [SEQ_W-1:0]  hdr_seq,
  input  logic [TS_W-1:0]   hdr_ts,
  input  logic              hdr_cap,
  input  logic [SW-1:0]     rd_slot,
  input  logic [WW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [SEQ_W-1:0]  rd_seq,
  output logic [TS_W-1:0]   rd_ts,
  output logic              rd_cap,
  output logic [LW-1:0]     rd_len
);
  logic [DATA_W-1:0] mem   [SLOTS*SLOT_WORDS];
  logic [SEQ_W-1:0]  seq_q [SLOTS];
  logic [TS_W-1:0]   ts_q  [SLOTS];
  logic              cap_q [SLOTS];
  logic [LW-1:0]     len_q [SLOTS];
  logic [AW-1:0]     wa, ra;

  always_comb begin
    wa = AW'(wr_slot) * AW'(SLOT_WORDS) + AW'(wr_addr);
    ra = AW'(rd_slot) * AW'(SLOT_WORDS) + AW'(rd_addr);
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wa] <= wr_data;
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < SLOTS; s++) begin
      if (wr_en && wr_slot == SW'(s)) len_q[s] <= wr_len;
      if (hdr_we && wr_slot == SW'(s)) begin
        seq_q[s] <= hdr_seq;
        ts_q[s]  <= hdr_ts;
        cap_q[s] <= hdr_cap;
      end
    end
  end

  assign rd_data = mem[ra];
  assign rd_seq  = seq_q[rd_slot];
  assign rd_ts   = ts_q[rd_slot];
  assign rd_cap  = cap_q[rd_slot];
  assign rd_len  = len_q[rd_slot];
endmodule

// File: rtl/frb_stats.sv
// Saturating loss counters with longest-run tracking.
module frb_stats #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       drop_inc,
  input  logic             ovr_inc,
  input  logic             commit,
  output logic [CNT_W-1:0] drop_cnt,
  output logic [CNT_W-1:0] max_run,
  output logic [CNT_W-1:0] ovr_cnt
);
  localparam logic [CNT_W:0] CMAX = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] drop_q, run_q, max_q, ovr_q;
  logic [CNT_W-1:0] drop_d, run_d, max_d, ovr_d, run_try;
  logic             upd;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + (CNT_W+1)'(b);
    return (s > CMAX) ? {CNT_W{1'b1}} : s[CNT_W-1:0];
  endfunction

  always_comb begin
    run_try = sat_add(run_q, drop_inc);
    drop_d  = sat_add(drop_q, drop_inc);
    ovr_d   = sat_add(ovr_q, {1'b0, ovr_inc});
    max_d   = (run_try > max_q) ? run_try : max_q;
    run_d   = commit ? '0 : run_try;
    upd     = (drop_inc != 2'd0) || ovr_inc || commit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_q <= '0;
      run_q  <= '0;
      max_q  <= '0;
      ovr_q  <= '0;
    end else if (upd) begin
      drop_q <= drop_d;
      run_q  <= run_d;
      max_q  <= max_d;
      ovr_q  <= ovr_d;
    end
  end

  assign drop_cnt = drop_q;
  assign max_run  = max_q;
  assign ovr_cnt  = ovr_q;
endmodule

// File: rtl/frame_ring_buf.sv
// Slot ring of whole frames with tags, near-full policy and loss counters.
module frame_ring_buf
  import frb_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SLOTS      = 4,
  parameter int SLOT_WORDS = 8,
  parameter int SEQ_W      = 8,
  parameter int TS_W       = 16,
  parameter int CNT_W      = 8,
  localparam int CW = $clog2(SLOTS + 1),
  localparam int SW = $clog2(SLOTS),
  localparam int WW = $clog2(SLOT_WORDS),
  localparam int LW = $clog2(SLOT_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_policy,
  input  logic [CW-1:0]     cfg_near_lvl,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_capture,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_throttle,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eof,
  output logic [DATA_W-1:0] out_data,
  output logic [SEQ_W-1:0]  out_seq,
  output logic [TS_W-1:0]   out_ts,
  output logic              out_capture,
  output logic [CNT_W-1:0]  drop_count,
  output logic [CNT_W-1:0]  drop_run_max,
  output logic [CNT_W-1:0]  overrun_count
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  // state
  logic [CW-1:0]    occ, occ_d;
  logic [SW-1:0]    wr_ptr, wr_ptr_d, rd_ptr, rd_ptr_d;
  logic             wr_act, wr_act_d;
  logic [LW-1:0]    wr_len, wr_len_d;
  logic [WW-1:0]    rd_idx, rd_idx_d;
  logic [SEQ_W-1:0] seq, seq_d;
  logic [TS_W-1:0]  ts;

  // datapath
  admit_e           verdict;
  logic             hs, rd_last, sof_beat, keep_new, evict, abandon, commit;
  logic             can_evict, word_we, ovr_inc;
  logic [1:0]       drop_inc;
  logic [WW-1:0]    wr_addr;
  logic [LW-1:0]    rd_len;
  logic             oldest_cap;

  function automatic logic [SW-1:0] slot_inc(input logic [SW-1:0] p);
    return (p == SW'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  frb_admit #(.SLOTS(SLOTS)) u_admit (
    .policy    (cfg_policy),
    .near_lvl  (cfg_near_lvl),
    .occ       (occ),
    .capture   (in_capture),
    .can_evict (can_evict),
    .throttle  (in_throttle),
    .verdict   (verdict)
  );

  always_comb begin
    out_valid = (occ != '0);
    hs        = out_valid && out_ready;
    rd_last   = (LW'(rd_idx) + LW'(1)) == rd_len;
    out_sof   = out_valid && (rd_idx == '0);
    out_eof   = out_valid && rd_last;
    can_evict = out_valid && (rd_idx == '0) && !hs && !oldest_cap;

    sof_beat  = in_valid && in_sof;
    keep_new  = sof_beat && (verdict == ADM_STORE || verdict == ADM_STORE_EVICT);
    evict     = sof_beat && (verdict == ADM_STORE_EVICT);
    abandon   = sof_beat && wr_act;
    ovr_inc   = sof_beat && (verdict == ADM_OVERRUN);
    drop_inc  = 2'(abandon) + 2'(evict)
              + 2'(sof_beat && (verdict == ADM_DROP || verdict == ADM_OVERRUN));

    word_we   = keep_new
              || (in_valid && !in_sof && wr_act && (wr_len < LW'(SLOT_WORDS)));
    wr_addr   = in_sof ? '0 : wr_len[WW-1:0];
    commit    = in_valid && in_eof && (keep_new || (!in_sof && wr_act));

    // next state
    if (sof_beat)                 wr_act_d = keep_new && !in_eof;
    else if (in_valid && in_eof)  wr_act_d = 1'b0;
    else                          wr_act_d = wr_act;
    if (sof_beat)                 wr_len_d = LW'(1);
    else if (word_we)             wr_len_d = wr_len + LW'(1);
    else                          wr_len_d = wr_len;

    wr_ptr_d = commit ? slot_inc(wr_ptr) : wr_ptr;
    rd_ptr_d = ((hs && rd_last) || evict) ? slot_inc(rd_ptr) : rd_ptr;
    rd_idx_d = hs ? (rd_last ? '0 : rd_idx + 1'b1) : rd_idx;
    occ_d    = occ + CW'(commit) - CW'(hs && rd_last) - CW'(evict);
    seq_d    = sof_beat ? seq + 1'b1 : seq;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      occ    <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      wr_act <= 1'b0;
      wr_len <= '0;
      rd_idx <= '0;
      seq    <= '0;
      ts     <= '0;
    end else begin
      occ    <= occ_d;
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      wr_act <= wr_act_d;
      wr_len <= wr_len_d;
      rd_idx <= rd_idx_d;
      seq    <= seq_d;
      ts     <= ts + 1'b1;
    end
  end

  frb_store #(
    .DATA_W(DATA_W), .SLOTS(SLOTS), .SLOT_WORDS(SLOT_WORDS),
    .SEQ_W(SEQ_W), .TS_W(TS_W)
  ) u_store (
    .clk     (clk),
    .wr_en   (word_we),
    .wr_slot (wr_ptr),
    .wr_addr (wr_addr),
    .wr_data (in_data),
    .wr_len  (wr_len_d),
    .hdr_we  (keep_new),
    .hdr_seq (seq),
    .hdr_ts  (ts),
    .hdr_cap (in_capture),
    .rd_slot (rd_ptr),
    .rd_addr (rd_idx),
    .rd_data (out_data),
    .rd_seq  (out_seq),
    .rd_ts   (out_ts),
    .rd_cap  (oldest_cap),
    .rd_len  (rd_len)
  );
  assign out_capture = oldest_cap;

  frb_stats #(.CNT_W(CNT_W)) u_stats (
    .clk      (clk),
    .rst_n    (srst_n),
    .drop_inc (drop_inc),
    .ovr_inc  (ovr_inc),
    .commit   (commit),
    .drop_cnt (drop_count),
    .max_run  (drop_run_max),
    .ovr_cnt  (overrun_count)
  );
endmodule

// File: rtl/frb_checks.sv
// Temporal checks, bound into frame_ring_buf.
module frb_checks #(
  parameter int DATA_W = 8,
  parameter int SLOTS  = 4,
  parameter int SEQ_W  = 8,
  parameter int CNT_W  = 8,
  localparam int CW = $clog2(SLOTS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CW-1:0]     occ,
  input logic              in_valid,
  input logic              in_sof,
  input logic              in_eof,
  input logic              in_throttle,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_sof,
  input logic [DATA_W-1:0] out_data,
  input logic [SEQ_W-1:0]  out_seq,
  input logic [CNT_W-1:0]  drop_cnt,
  input logic [CNT_W-1:0]  max_run,
  input logic [CNT_W-1:0]  ovr_cnt
);
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(SLOTS));

  p_full_throttle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CW'(SLOTS)) |-> in_throttle);

  p_commit_on_eof_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ > $past(occ)) |-> $past(in_valid && in_eof));

  p_overrun_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_cnt != $past(ovr_cnt)) |-> $past(in_throttle && in_valid && in_sof));

  p_drop_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt != $past(drop_cnt)) |-> (drop_cnt > $past(drop_cnt)));

  p_run_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    max_run <= drop_cnt);

  p_hold_midframe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !out_sof) |=>
      (out_valid && $stable(out_data) && $stable(out_seq)));
endmodule

bind frame_ring_buf frb_checks #(
  .DATA_W(DATA_W), .SLOTS(SLOTS), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (srst_n),
  .occ        (occ),
  .in_valid   (in_valid),
  .in_sof     (in_sof),
  .in_eof     (in_eof),
  .in_throttle(in_throttle),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_sof    (out_sof),
  .out_data   (out_data),
  .out_seq    (out_seq),
  .drop_cnt   (drop_count),
  .max_run    (drop_run_max),
  .ovr_cnt    (overrun_count)
);

// File: tb/frame_ring_buf_test.sv
module frame_ring_buf_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_policy = 2'd0;
  logic [2:0] cfg_near_lvl = 3'd2;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_capture = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic       in_throttle;
  logic       out_ready = 1'b0;
  logic       out_valid, out_sof, out_eof, out_capture;
  logic [7:0] out_data, out_seq;
  logic [15:0] out_ts;
  logic [7:0] drop_count, drop_run_max, overrun_count;

  always #10 clk = ~clk;

  frame_ring_buf uut (
    .clk(clk), .rst_n(rst_n), .cfg_policy(cfg_policy), .cfg_near_lvl(cfg_near_lvl),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_capture(in_capture),
    .in_data(in_data), .in_throttle(in_throttle), .out_ready(out_ready),
    .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data),
    .out_seq(out_seq), .out_ts(out_ts), .out_capture(out_capture),
    .drop_count(drop_count), .drop_run_max(drop_run_max), .overrun_count(overrun_count)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int nseq, exp_n;
  int f_len [32];
  int f_cap [32];
  int f_cyc [32];
  int exp_seq [16];

  // row: [14] capture, [13:10] length, [9] stored, [8] throttle after,
  //      [7:4] drops after, [3:0] overruns after  (policy 0, level 2)
  localparam logic [14:0] TBL [7] = '{
    {1'b0, 4'd3, 1'b1, 1'b0, 4'd0, 4'd0},
    {1'b0, 4'd2, 1'b1, 1'b0, 4'd0, 4'd0},
    {1'b0, 4'd4, 1'b0, 1'b0, 4'd1, 4'd0},
    {1'b1, 4'd3, 1'b1, 1'b0, 4'd1, 4'd0},
    {1'b1, 4'd1, 1'b1, 1'b1, 4'd1, 4'd0},
    {1'b0, 4'd2, 1'b0, 1'b1, 4'd2, 4'd0},
    {1'b1, 4'd2, 1'b0, 1'b1, 4'd3, 4'd1}
  };

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] pol, input logic [2:0] lvl);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; out_ready = 1'b0;
    cfg_policy = pol; cfg_near_lvl = lvl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    nseq = 0; exp_n = 0;
  endtask

  task automatic send_frame(input bit cap, input int len, input bit keep, input bit fin);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = fin && (i == len - 1);
      in_capture = cap; in_data = {nseq[3:0], i[3:0]};
      if (i == 0) f_cyc[nseq] = cyc;
    end
    f_len[nseq] = len; f_cap[nseq] = cap;
    if (keep) begin exp_seq[exp_n] = nseq; exp_n++; end
    nseq++;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic drain(string req);
    int ts_prev = 0, prev_s = 0;
    out_ready = 1'b1;
    for (int k = 0; k < exp_n; k++) begin
      int s, bad, ts0;
      s = exp_seq[k]; bad = 0; ts0 = 0;
      for (int i = 0; i < f_len[s]; i++) begin
        if (!out_valid || out_sof != (i == 0) || out_eof != (i == f_len[s] - 1) ||
            out_data != {s[3:0], i[3:0]} || out_seq != s[7:0] ||
            out_capture != f_cap[s][0]) bad++;
        if (i == 0) ts0 = int'(out_ts);
        @(negedge clk);
      end
      chk(req, $sformatf("R3 frame %0d words mismatched", s), bad, 0);
      if (k > 0)
        chk("R1", "timestamp step", (ts0 - ts_prev) & 16'hFFFF,
            (f_cyc[s] - f_cyc[prev_s]) & 16'hFFFF);
      ts_prev = ts0; prev_s = s;
    end
    chk(req, "ring empty after drain", int'(out_valid), 0);
    out_ready = 1'b0;
  endtask

  initial begin
    // R11: reset state
    do_reset(2'd0, 3'd2);
    chk("R11", "out_valid", int'(out_valid), 0);
    chk("R11", "drop_count", int'(drop_count), 0);
    chk("R11", "overrun_count", int'(overrun_count), 0);
    chk("R11", "drop_run_max", int'(drop_run_max), 0);
    chk("R11", "in_throttle", int'(in_throttle), 0);

    // table walk: R4 R7 R8 under drop-new
    for (int k = 0; k < 7; k++) begin
      send_frame(TBL[k][14], int'(TBL[k][13:10]), TBL[k][9], 1'b1);
      chk("R4 R7 R8", $sformatf("row %0d drops", k), int'(drop_count), int'(TBL[k][7:4]));
      chk("R4 R7 R8", $sformatf("row %0d overruns", k), int'(overrun_count), int'(TBL[k][3:0]));
      chk("R4 R7 R8", $sformatf("row %0d throttle", k), int'(in_throttle), int'(TBL[k][8]));
    end
    chk("R10", "longest drop run", int'(drop_run_max), 2);
    drain("R1 R3");

    // R2 R9: partial frame is invisible, then abandoned
    do_reset(2'd0, 3'd4);
    send_frame(1'b0, 3, 1'b0, 1'b0);
    chk("R2", "out_valid before eof", int'(out_valid), 0);
    send_frame(1'b0, 2, 1'b1, 1'b1);
    chk("R9", "drop after abandon", int'(drop_count), 1);
    drain("R9");

    // R5: keep latest evicts oldest preview
    do_reset(2'd1, 3'd2);
    send_frame(1'b0, 2, 1'b0, 1'b1);
    send_frame(1'b0, 2, 1'b0, 1'b1);
    send_frame(1'b0, 3, 1'b1, 1'b1);
    chk("R5", "drop after first eviction", int'(drop_count), 1);
    send_frame(1'b1, 2, 1'b1, 1'b1);
    chk("R7", "capture stored near full", int'(drop_count), 1);
    send_frame(1'b0, 2, 1'b1, 1'b1);
    chk("R5", "drop after second eviction", int'(drop_count), 2);
    drain("R5");

    // R7: oldest capture frame is not evicted
    do_reset(2'd1, 3'd1);
    send_frame(1'b1, 2, 1'b1, 1'b1);
    send_frame(1'b0, 2, 1'b1, 1'b1);
    chk("R7", "no eviction of capture", int'(drop_count), 0);
    drain("R7");

    // R6: throttle policy
    do_reset(2'd2, 3'd1);
    chk("R6", "throttle while empty", int'(in_throttle), 0);
    send_frame(1'b0, 2, 1'b1, 1'b1);
    chk("R6", "throttle at level", int'(in_throttle), 1);
    send_frame(1'b0, 2, 1'b0, 1'b1);
    chk("R6", "overrun count", int'(overrun_count), 1);
    chk("R6", "overrun also dropped", int'(drop_count), 1);
    drain("R6");
    chk("R6", "throttle released", int'(in_throttle), 0);

    // R8: full forces throttle in keep-latest mode
    do_reset(2'd1, 3'd4);
    for (int k = 0; k < 4; k++) send_frame(1'b1, 2, 1'b1, 1'b1);
    chk("R8", "throttle when full", int'(in_throttle), 1);
    send_frame(1'b1, 2, 1'b0, 1'b1);
    chk("R8", "capture overrun when full", int'(overrun_count), 1);
    drain("R8");
    chk("R8", "throttle after drain", int'(in_throttle), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule